// File: doc/BRIEF.md
# Addressed Serial Segment-Data Receiver

This block takes display data from a write-only serial link of two or three wires: a data clock, a data line and an optional enable line. A system clock samples the link lines, so the link runs asynchronously to the block. A transfer opens with a start condition. An address byte follows, and it is compared against three address-select pins. When the address matches, the following data bits are shifted into a 128-bit shift register.

A full 128-bit block is copied into a display word in one of two ways. The first is automatic: the copy happens when the block completes while enable is high. The second is external: enable is held low, and a rising enable while the data clock is high triggers the copy. Each copy is marked by a one-cycle strobe. If the link is left open after a block, the next rising clock edge is swallowed and reception continues block by block. A stop condition aborts reception at any point. The select pins also report whether this device is the master of a cascaded group.

Top module: `seg_link_rx`

## Requirements
- R1: The link idles with clock and data high. Data falling while clock is high is a start condition, and it resets the bit count. Data rising while clock is high is a stop condition. Data changes while clock is low are not conditions.
- R2: The 8 bits after a start are taken MSB first as an address. The address matches only when it equals {0111, A2, A1, A0, 0}, where A2..A0 is `addr_sel_i[2:0]`. This means the least significant bit must be 0.
- R3: A select value of 000 never matches, whatever address is sent.
- R4: `is_master_o` is 1 exactly when `addr_sel_i` is 111.
- R5: After a match, each rising data-clock edge shifts in one data bit. The first bit of a 128-bit block ends up in `disp_o[127]` and the last bit in `disp_o[0]`. A device that is not addressed ignores the data.
- R6: When a 128-bit block completes while enable is high, the block is copied to `disp_o`, and `disp_upd_o` pulses high for one system-clock cycle.
- R7: When a block completes while enable is low, `disp_o` is not changed. A rising enable while the data clock is high copies the shift register to `disp_o`.
- R8: If the link stays open after a block, the next rising clock edge shifts nothing. The edge after that starts the next 128-bit block, which is latched like the first one.
- R9: A stop condition ends reception at once. No data is accepted again until a new start condition and a matching address have been sent.
- R10: Reset clears `disp_o` to 0 and `disp_upd_o` to 0. `disp_o` holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial data clock; high when idle |
| sdat_i | input | 1 | Serial data line; high when idle |
| sen_i | input | 1 | Latch enable: high selects automatic latching, a rising edge while the data clock is high latches now |
| addr_sel_i | input | 3 | Address-select pins A2..A0 |
| disp_o | output | 128 | Latched display word |
| disp_upd_o | output | 1 | One-cycle strobe when `disp_o` is loaded |
| is_master_o | output | 1 | High when the select pins are 111 |

## Verification
Two latch paths can act in the same system-clock cycle region. The first is the rising enable, which copies the shift register at once. The second is the automatic copy when a block completes. The bench provokes both together by raising enable and the data clock for the 128th bit at the same instant, with enable low beforehand. The enable path then fires one cycle before the block-complete path, so it captures a 127-bit word. The automatic path then overwrites it. The check therefore requires that the word left in `disp_o` is the complete block, not the partial copy taken one cycle earlier.

// File: rtl/seg_link_pkg.sv
package seg_link_pkg;

  localparam int ADDR_BITS = 8;
  localparam logic [3:0] ADDR_PREFIX = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP,
    ST_DROP
  } rx_state_t;

  // Address byte matches: fixed prefix, select pins, write bit 0; 000 never.
  function automatic logic addr_hit(input logic [ADDR_BITS-1:0] abyte,
                                    input logic [2:0] sel);
    logic ok_sel;
    ok_sel = (sel != 3'b000);
    return ok_sel && (abyte == {ADDR_PREFIX, sel, 1'b0});
  endfunction

  function automatic logic sel_is_master(input logic [2:0] sel);
    return &sel;
  endfunction

endpackage

// File: rtl/seg_line_sync.sv
module seg_line_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= raw_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= RST_VAL;
    else prev_o <= chain[STAGES-1];
  end

  assign cur_o = chain[STAGES-1];
endmodule

// File: rtl/seg_bus_events.sv
module seg_bus_events (
  input  logic clk_cur_i,
  input  logic clk_prev_i,
  input  logic dat_cur_i,
  input  logic dat_prev_i,
  input  logic en_cur_i,
  input  logic en_prev_i,
  output logic sclk_rise_o,
  output logic start_o,
  output logic stop_o,
  output logic en_hit_o,
  output logic en_lvl_o
);
  logic clk_held_hi;

  always_comb begin
    clk_held_hi = clk_cur_i && clk_prev_i;
    sclk_rise_o = clk_cur_i && !clk_prev_i;
    start_o     = clk_held_hi && dat_prev_i && !dat_cur_i;
    stop_o      = clk_held_hi && !dat_prev_i && dat_cur_i;
    en_hit_o    = en_cur_i && !en_prev_i && clk_cur_i;
    en_lvl_o    = en_cur_i;
  end
endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
  import seg_link_pkg::*;
#(
  parameter int DATA_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 sclk_rise_i,
  input  logic                 sdat_i,
  input  logic [2:0]           sel_i,
  output logic [DATA_BITS-1:0] shreg_o,
  output logic                 blk_done_o,
  output logic                 rx_active_o,
  output logic                 in_skip_o
);
  localparam int CW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_BITS - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_BITS - 1);

  rx_state_t              state;
  logic [CW-1:0]          cnt;
  logic [ADDR_BITS-1:0]   addr_sr;
  logic [ADDR_BITS-1:0]   addr_next;
  logic [DATA_BITS-1:0]   shreg;

  assign addr_next = {addr_sr[ADDR_BITS-2:0], sdat_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      addr_sr    <= '0;
      shreg      <= '0;
      blk_done_o <= 1'b0;
    end else begin
      blk_done_o <= 1'b0;
      if (start_i) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (sclk_rise_i) begin
        unique case (state)
          ST_ADDR: begin
            addr_sr <= addr_next;
            if (cnt == ADDR_LAST) begin
              cnt   <= '0;
              state <= addr_hit(addr_next, sel_i) ? ST_DATA : ST_DROP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            shreg <= {shreg[DATA_BITS-2:0], sdat_i};
            if (cnt == DATA_LAST) begin
              cnt        <= '0;
              state      <= ST_SKIP;
              blk_done_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SKIP: state <= ST_DATA;
          default: ;
        endcase
      end
    end
  end

  assign shreg_o     = shreg;
  assign rx_active_o = (state == ST_DATA) || (state == ST_SKIP);
  assign in_skip_o   = (state == ST_SKIP);
endmodule

// File: rtl/seg_disp_latch.sv
module seg_disp_latch #(
  parameter int DATA_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 blk_done_i,
  input  logic                 en_lvl_i,
  input  logic                 en_hit_i,
  input  logic [DATA_BITS-1:0] shreg_i,
  output logic [DATA_BITS-1:0] disp_o,
  output logic                 upd_o
);
  logic take;

  assign take = (blk_done_i && en_lvl_i) || en_hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= take;
      if (take) disp_o <= shreg_i;
    end
  end
endmodule

// File: rtl/seg_link_rx.sv
module seg_link_rx
  import seg_link_pkg::*;
#(
  parameter int DATA_BITS = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 sdat_i,
  input  logic                 sen_i,
  input  logic [2:0]           addr_sel_i,
  output logic [DATA_BITS-1:0] disp_o,
  output logic                 disp_upd_o,
  output logic                 is_master_o
);
  logic [2:0]           line_cur;
  logic [2:0]           line_prev;
  logic                 sclk_rise_w;
  logic                 start_w;
  logic                 stop_w;
  logic                 en_hit_w;
  logic                 en_lvl_w;
  logic                 blk_done_w;
  logic                 rx_active_w;
  logic                 skip_w;
  logic [DATA_BITS-1:0] shreg_w;

  seg_line_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b111)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sen_i, sdat_i, sclk_i}),
    .cur_o  (line_cur),
    .prev_o (line_prev)
  );

  seg_bus_events u_evt (
    .clk_cur_i   (line_cur[0]),
    .clk_prev_i  (line_prev[0]),
    .dat_cur_i   (line_cur[1]),
    .dat_prev_i  (line_prev[1]),
    .en_cur_i    (line_cur[2]),
    .en_prev_i   (line_prev[2]),
    .sclk_rise_o (sclk_rise_w),
    .start_o     (start_w),
    .stop_o      (stop_w),
    .en_hit_o    (en_hit_w),
    .en_lvl_o    (en_lvl_w)
  );

  seg_frame_rx #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .sclk_rise_i (sclk_rise_w),
    .sdat_i      (line_cur[1]),
    .sel_i       (addr_sel_i),
    .shreg_o     (shreg_w),
    .blk_done_o  (blk_done_w),
    .rx_active_o (rx_active_w),
    .in_skip_o   (skip_w)
  );

  seg_disp_latch #(.DATA_BITS(DATA_BITS)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_done_i (blk_done_w),
    .en_lvl_i   (en_lvl_w),
    .en_hit_i   (en_hit_w),
    .shreg_i    (shreg_w),
    .disp_o     (disp_o),
    .upd_o      (disp_upd_o)
  );

  assign is_master_o = sel_is_master(addr_sel_i);
endmodule

// File: rtl/seg_link_rx_chk.sv
module seg_link_rx_chk #(
  parameter int DATA_BITS = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           addr_sel_i,
  input logic [DATA_BITS-1:0] disp_o,
  input logic                 disp_upd_o,
  input logic                 sclk_rise_w,
  input logic                 stop_w,
  input logic                 en_hit_w,
  input logic                 en_lvl_w,
  input logic                 blk_done_w,
  input logic                 rx_active_w,
  input logic                 skip_w,
  input logic [DATA_BITS-1:0] shreg_w
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_upd_o |-> $stable(disp_o));

  assert_upd_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_upd_o |-> $past(blk_done_w || en_hit_w));

  assert_auto_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done_w && en_lvl_w) |=> disp_upd_o);

  assert_no_zero_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active_w |-> (addr_sel_i != 3'b000));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !rx_active_w);

  assert_skip_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_w && sclk_rise_w) |=> $stable(shreg_w));
endmodule

bind seg_link_rx seg_link_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_sel_i  (addr_sel_i),
  .disp_o      (disp_o),
  .disp_upd_o  (disp_upd_o),
  .sclk_rise_w (sclk_rise_w),
  .stop_w      (stop_w),
  .en_hit_w    (en_hit_w),
  .en_lvl_w    (en_lvl_w),
  .blk_done_w  (blk_done_w),
  .rx_active_w (rx_active_w),
  .skip_w      (skip_w),
  .shreg_w     (shreg_w)
);

// File: tb/seg_link_rx_tb.sv
module seg_link_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 128;
  localparam int NVEC = 7;
  // {sel[2:0], address byte[7:0], expected match}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'b111, 8'h7E, 1'b1},
    {3'b101, 8'h7A, 1'b1},
    {3'b101, 8'h7E, 1'b0},
    {3'b001, 8'h72, 1'b1},
    {3'b000, 8'h70, 1'b0},
    {3'b110, 8'h7D, 1'b0},
    {3'b011, 8'h66, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic sdat = 1'b1;
  logic sen = 1'b1;
  logic [2:0] sel = 3'b111;
  logic [NB-1:0] disp;
  logic upd;
  logic master;

  int checks = 0;
  int errors = 0;
  int upd_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_link_rx u_dut (
    .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sdat_i (sdat), .sen_i (sen),
    .addr_sel_i (sel), .disp_o (disp), .disp_upd_o (upd), .is_master_o (master)
  );

  always @(posedge clk) if (upd) upd_cnt <= upd_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [NB-1:0] act,
                     input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b0; wclk(2);
    sdat = b;    wclk(2);
    sclk = 1'b1; wclk(4);
  endtask

  task automatic do_start();
    sclk = 1'b1; sdat = 1'b1; wclk(4);
    sdat = 1'b0; wclk(4);
  endtask

  task automatic do_stop();
    sclk = 1'b0; wclk(2);
    sdat = 1'b0; wclk(2);
    sclk = 1'b1; wclk(4);
    sdat = 1'b1; wclk(4);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic word_out(input logic [NB-1:0] w, input int nbits);
    for (int i = NB-1; i >= NB-nbits; i--) bit_out(w[i]);
  endtask

  function automatic logic [NB-1:0] pat(input int k);
    logic [31:0] s;
    s = 32'h9E37_79B9 * (k + 3);
    return {s, ~s, s ^ 32'h0F0F_1234, {s[15:0], s[31:16]}};
  endfunction

  initial begin
    logic [NB-1:0] prev;
    logic [NB-1:0] w;
    int u0;
    wclk(5);
    // R10 reset state, R4 master flag
    chk(disp == '0, "R10 reset display", disp, '0);
    chk(upd == 1'b0, "R10 reset strobe", NB'(upd), '0);
    rst_n = 1'b1;
    wclk(4);
    chk(master == 1'b1, "R4 master at 111", NB'(master), NB'(1));

    // Table: R1 framing, R2 address, R3 zero select, R5 shifting, R6 auto latch
    for (int v = 0; v < NVEC; v++) begin
      sel = VEC[v][11:9];
      wclk(4);
      chk(master == (sel == 3'b111), "R4 master flag", NB'(master), NB'(sel == 3'b111));
      prev = disp;
      u0 = upd_cnt;
      w = pat(v);
      do_start();
      byte_out(VEC[v][8:1]);
      word_out(w, NB);
      wclk(8);
      do_stop();
      wclk(6);
      if (VEC[v][0]) begin
        chk(disp == w, "R5 R6 addressed block latched", disp, w);
        chk(upd_cnt - u0 == 1, "R6 single strobe", NB'(upd_cnt - u0), NB'(1));
      end else begin
        chk(disp == prev, "R2 R3 unaddressed ignored", disp, prev);
        chk(upd_cnt == u0, "R2 R3 no strobe", NB'(upd_cnt - u0), '0);
      end
    end

    // R7 enable held low, then pulse while clock high
    sel = 3'b010; wclk(4);
    prev = disp; w = pat(20);
    sen = 1'b0; wclk(4);
    do_start(); byte_out(8'h74); word_out(w, NB); wclk(10);
    chk(disp == prev, "R7 enable low holds display", disp, prev);
    sen = 1'b1; wclk(6);
    chk(disp == w, "R7 enable pulse latches", disp, w);
    do_stop(); wclk(6);

    // R8 free-running link: 129th edge swallowed, second block latched
    w = pat(30); prev = pat(31);
    do_start(); byte_out(8'h74);
    word_out(w, NB); wclk(8);
    chk(disp == w, "R8 first block", disp, w);
    bit_out(1'b1);
    word_out(prev, NB); wclk(8);
    chk(disp == prev, "R8 second block after skipped edge", disp, prev);
    do_stop(); wclk(6);

    // R9 abort, then bare clocks without start are ignored
    w = pat(40);
    do_start(); byte_out(8'h74); word_out(w, 40); do_stop();
    word_out(w, NB); word_out(w, NB); wclk(10);
    chk(disp == prev, "R9 no data after abort", disp, prev);
    do_start(); byte_out(8'h74); word_out(w, NB); do_stop(); wclk(6);
    chk(disp == w, "R9 new start and address accepted", disp, w);

    // R1 a start mid-block restarts the count at the address
    prev = pat(50);
    do_start(); byte_out(8'h74); word_out(pat(51), 70);
    do_start(); byte_out(8'h74); word_out(prev, NB); do_stop(); wclk(6);
    chk(disp == prev, "R1 restart resets bit count", disp, prev);

    // R7 R6 enable rising together with the 128th clock edge
    w = pat(60);
    sen = 1'b0; wclk(4);
    do_start(); byte_out(8'h74); word_out(w, NB-1);
    sclk = 1'b0; wclk(2); sdat = w[0]; wclk(2);
    sclk = 1'b1; sen = 1'b1; wclk(12);
    chk(disp == w, "R7 R6 coincident enable and block end", disp, w);
    do_stop(); wclk(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule